// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational stage sits in front of a fused multiply-add datapath that computes `z + (x * y)`, or `z - (x * y)` when the negate-product control is set. It takes a class code, a sign and the raw 64-bit encoding for each of the three double-precision operands. It decides whether the answer is already fixed by the operand classes: a NaN, an infinity, the unchanged addend or the default NaN. In that case it drives the special result and a valid flag, so the arithmetic can be skipped.

When no special case applies, the stage raises a proceed signal. Alongside it go per-operand requests to normalize denormal inputs, and the effective product sign for the datapath to use. NaN selection follows a fixed priority across all three operands. Product classes are paired with the addend class, instead of applying two-operand NaN rules twice.

Top module: `fma_special_resolve`

## Requirements
- R1: Class codes are ZERO=0, NORM=1, DNORM=2, INF=3, QNAN=4, SNAN=5. For every input, exactly one of `bypassValid` and `proceed` is high.
- R2: A signalling-NaN addend overrides every other case. The result is the addend with fraction bit 51 set and all other bits kept, and `invalidOp` is high.
- R3: With the addend not a signalling NaN, a signalling-NaN x gives x quieted (bit 51 set) with `invalidOp` high, whatever y is. Otherwise a signalling-NaN y gives y quieted with `invalidOp` high.
- R4: With no signalling NaN present, a quiet-NaN x is returned bit for bit. Otherwise a quiet-NaN y is returned bit for bit. `invalidOp` stays low in both cases.
- R5: With no factor NaN and no signalling-NaN addend, a quiet-NaN addend is returned bit for bit with `invalidOp` low. This includes the infinity-times-zero case.
- R6: Infinity times zero, in either factor order and with a non-NaN addend, gives the default NaN 0x7FF8000000000000 with `invalidOp` high.
- R7: An infinite product (infinity times nonzero or infinity) gives infinity carrying the product sign. If the addend is infinity of the opposite sign, the result is instead the default NaN with `invalidOp` high.
- R8: A zero product (zero times a finite value) with an infinite addend gives infinity with the addend's sign. With any other non-NaN addend, the addend is returned bit for bit.
- R9: A finite nonzero product with an infinite addend gives infinity with the addend's sign.
- R10: A finite nonzero product with a finite addend raises `proceed` and holds `bypassResult` at zero. It raises `normReqZ`, `normReqX` and `normReqY` exactly for the operands classed DNORM. The normalize requests are low whenever `proceed` is low.
- R11: `prodSign` is the XOR of the two factor signs, inverted when `negProduct` is high. This sign is the one used in R7 and the one-sign comparison against the addend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| zClass | input | 3 | Class code of the addend |
| xClass | input | 3 | Class code of the first factor |
| yClass | input | 3 | Class code of the second factor |
| zSign | input | 1 | Sign of the addend |
| xSign | input | 1 | Sign of the first factor |
| ySign | input | 1 | Sign of the second factor |
| negProduct | input | 1 | Invert the product sign (multiply-subtract) |
| zRaw | input | 64 | Raw encoding of the addend |
| xRaw | input | 64 | Raw encoding of the first factor |
| yRaw | input | 64 | Raw encoding of the second factor |
| bypassValid | output | 1 | Special result is final |
| bypassResult | output | 64 | Special result encoding, zero when proceeding |
| invalidOp | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Normal datapath must compute the result |
| normReqZ | output | 1 | Addend needs denormal normalization |
| normReqX | output | 1 | First factor needs denormal normalization |
| normReqY | output | 1 | Second factor needs denormal normalization |
| prodSign | output | 1 | Effective product sign |

## Verification
The block holds no state, so a wrong internal decision shows at the ports for the same input vector, within the one cycle that the bench allows between driving and sampling. A wrong priority shows up in one of two ways. One is the wrong operand's payload in `bypassResult`. The other is a missing quiet bit or a wrong `invalidOp` value. A lost case in the pairing of product class and addend class shows up as a wrong choice between `bypassValid` and `proceed`, or as an infinity with the wrong sign. The bench compares every port field against a reference ordering built from the requirements. It uses random class mixes and directed collisions of NaN, infinity and zero.

// File: rtl/fmaSpecialPkg.sv
package fmaSpecialPkg;

  typedef enum logic [2:0] {
    CLS_ZERO  = 3'd0,
    CLS_NORM  = 3'd1,
    CLS_DNORM = 3'd2,
    CLS_INF   = 3'd3,
    CLS_QNAN  = 3'd4,
    CLS_SNAN  = 3'd5
  } opClass_e;

  // Source selector for the bypass result
  typedef enum logic [2:0] {
    PICK_NONE = 3'd0,
    PICK_Z    = 3'd1,
    PICK_X    = 3'd2,
    PICK_Y    = 3'd3,
    PICK_DFLT = 3'd4,
    PICK_INF  = 3'd5
  } pick_e;

  // Strobes from control to datapath
  typedef struct packed {
    pick_e      pick;
    logic       quiet;
    logic       infSign;
    logic       invalid;
    logic       proceed;
    logic [2:0] normReq;   // {z, y, x}
  } strobe_t;

  localparam int OP_Z = 0;
  localparam int OP_X = 1;
  localparam int OP_Y = 2;
  localparam int NUM_OPS = 3;

endpackage

// File: rtl/fmaSpecialCtrl.sv
module fmaSpecialCtrl
  import fmaSpecialPkg::*;
(
  input  opClass_e zCls,
  input  opClass_e xCls,
  input  opClass_e yCls,
  input  logic     zSign,
  input  logic     xSign,
  input  logic     ySign,
  input  logic     negProduct,
  output strobe_t  ctl,
  output logic     prodSign
);

  logic xSnan, ySnan, zSnan, xQnan, yQnan, zQnan;
  logic prodInf, prodZero, zInf;

  always_comb begin
    xSnan    = (xCls == CLS_SNAN);
    ySnan    = (yCls == CLS_SNAN);
    zSnan    = (zCls == CLS_SNAN);
    xQnan    = (xCls == CLS_QNAN);
    yQnan    = (yCls == CLS_QNAN);
    zQnan    = (zCls == CLS_QNAN);
    zInf     = (zCls == CLS_INF);
    prodInf  = (xCls == CLS_INF) || (yCls == CLS_INF);
    prodZero = (xCls == CLS_ZERO) || (yCls == CLS_ZERO);
  end

  assign prodSign = xSign ^ ySign ^ negProduct;

  // Fixed priority decision chain
  always_comb begin
    ctl = '0;
    ctl.pick = PICK_NONE;
    if (zSnan) begin
      ctl.pick = PICK_Z; ctl.quiet = 1'b1; ctl.invalid = 1'b1;
    end else if (xSnan) begin
      ctl.pick = PICK_X; ctl.quiet = 1'b1; ctl.invalid = 1'b1;
    end else if (ySnan) begin
      ctl.pick = PICK_Y; ctl.quiet = 1'b1; ctl.invalid = 1'b1;
    end else if (xQnan) begin
      ctl.pick = PICK_X;
    end else if (yQnan) begin
      ctl.pick = PICK_Y;
    end else if (zQnan) begin
      ctl.pick = PICK_Z;
    end else if (prodInf && prodZero) begin
      ctl.pick = PICK_DFLT; ctl.invalid = 1'b1;
    end else if (prodInf) begin
      if (zInf && (zSign != prodSign)) begin
        ctl.pick = PICK_DFLT; ctl.invalid = 1'b1;
      end else begin
        ctl.pick = PICK_INF; ctl.infSign = prodSign;
      end
    end else if (zInf) begin
      ctl.pick = PICK_INF; ctl.infSign = zSign;
    end else if (prodZero) begin
      ctl.pick = PICK_Z;
    end else begin
      ctl.proceed = 1'b1;
      ctl.normReq = {zCls == CLS_DNORM, yCls == CLS_DNORM, xCls == CLS_DNORM};
    end
  end

  // Guards on the strobe bundle
  always_comb begin
    p_one_path_r1: assert ($onehot({ctl.pick != PICK_NONE, ctl.proceed}));
    p_norm_gated_r10: assert (ctl.proceed || (ctl.normReq == 3'b000));
    p_invalid_src_r6: assert (!ctl.invalid || ctl.quiet || (ctl.pick == PICK_DFLT));
    p_quiet_snan_r3: assert (!ctl.quiet || ctl.invalid);
  end

endmodule

// File: rtl/fmaSpecialData.sv
module fmaSpecialData
  import fmaSpecialPkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  strobe_t                    ctl,
  input  logic [EXP_W+FRAC_W:0]      zRaw,
  input  logic [EXP_W+FRAC_W:0]      xRaw,
  input  logic [EXP_W+FRAC_W:0]      yRaw,
  output logic                       bypassValid,
  output logic [EXP_W+FRAC_W:0]      bypassResult
);

  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] DFLT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [W-1:0] opRaw [NUM_OPS];
  logic [W-1:0] opOut [NUM_OPS];

  assign opRaw[OP_Z] = zRaw;
  assign opRaw[OP_X] = xRaw;
  assign opRaw[OP_Y] = yRaw;

  // Per-operand quieting path
  for (genvar i = 0; i < NUM_OPS; i++) begin : gQuiet
    always_comb begin
      opOut[i] = opRaw[i];
      if (ctl.quiet) opOut[i][QBIT] = 1'b1;
    end
  end

  always_comb begin
    unique case (ctl.pick)
      PICK_Z:    bypassResult = opOut[OP_Z];
      PICK_X:    bypassResult = opOut[OP_X];
      PICK_Y:    bypassResult = opOut[OP_Y];
      PICK_DFLT: bypassResult = DFLT_NAN;
      PICK_INF:  bypassResult = {ctl.infSign, INF_MAG};
      default:   bypassResult = '0;
    endcase
  end

  assign bypassValid = (ctl.pick != PICK_NONE);

  // Shape checks on the formed result
  always_comb begin
    p_quiet_shape_r2: assert (!(bypassValid && ctl.quiet) || bypassResult[QBIT]);
    p_inf_shape_r7: assert (!(ctl.pick == PICK_INF) ||
                            (bypassResult[W-2:0] == INF_MAG));
    p_idle_zero_r10: assert (bypassValid || (bypassResult == '0));
  end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fmaSpecialPkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [2:0]              zClass,
  input  logic [2:0]              xClass,
  input  logic [2:0]              yClass,
  input  logic                    zSign,
  input  logic                    xSign,
  input  logic                    ySign,
  input  logic                    negProduct,
  input  logic [EXP_W+FRAC_W:0]   zRaw,
  input  logic [EXP_W+FRAC_W:0]   xRaw,
  input  logic [EXP_W+FRAC_W:0]   yRaw,
  output logic                    bypassValid,
  output logic [EXP_W+FRAC_W:0]   bypassResult,
  output logic                    invalidOp,
  output logic                    proceed,
  output logic                    normReqZ,
  output logic                    normReqX,
  output logic                    normReqY,
  output logic                    prodSign
);

  strobe_t ctl;

  fmaSpecialCtrl uCtrl (
    .zCls       (opClass_e'(zClass)),
    .xCls       (opClass_e'(xClass)),
    .yCls       (opClass_e'(yClass)),
    .zSign      (zSign),
    .xSign      (xSign),
    .ySign      (ySign),
    .negProduct (negProduct),
    .ctl        (ctl),
    .prodSign   (prodSign)
  );

  fmaSpecialData #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uData (
    .ctl          (ctl),
    .zRaw         (zRaw),
    .xRaw         (xRaw),
    .yRaw         (yRaw),
    .bypassValid  (bypassValid),
    .bypassResult (bypassResult)
  );

  assign invalidOp = ctl.invalid;
  assign proceed   = ctl.proceed;
  assign normReqX  = ctl.normReq[0];
  assign normReqY  = ctl.normReq[1];
  assign normReqZ  = ctl.normReq[2];

endmodule

// File: tb/fma_special_resolve_test.sv
`timescale 1ns/1ps
module fma_special_resolve_test;

  localparam int C_ZERO = 0, C_NORM = 1, C_DNORM = 2, C_INF = 3, C_QNAN = 4, C_SNAN = 5;
  localparam logic [63:0] DNAN = 64'h7FF8000000000000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  zClass, xClass, yClass;
  logic        zSign, xSign, ySign, negProduct;
  logic [63:0] zRaw, xRaw, yRaw;
  logic        bypassValid, invalidOp, proceed, normReqZ, normReqX, normReqY, prodSign;
  logic [63:0] bypassResult;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  fma_special_resolve uut (
    .zClass(zClass), .xClass(xClass), .yClass(yClass),
    .zSign(zSign), .xSign(xSign), .ySign(ySign), .negProduct(negProduct),
    .zRaw(zRaw), .xRaw(xRaw), .yRaw(yRaw),
    .bypassValid(bypassValid), .bypassResult(bypassResult), .invalidOp(invalidOp),
    .proceed(proceed), .normReqZ(normReqZ), .normReqX(normReqX), .normReqY(normReqY),
    .prodSign(prodSign)
  );

  function automatic logic [63:0] mkRaw(int cls, logic s);
    logic [51:0] f;
    f = {$urandom(), $urandom()};
    case (cls)
      C_ZERO:  return {s, 63'd0};
      C_NORM:  return {s, 11'(1 + $urandom_range(2045, 0)), f};
      C_DNORM: return {s, 11'd0, f | 52'd1};
      C_INF:   return {s, 11'h7FF, 52'd0};
      C_QNAN:  return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:0] | 51'd1};
    endcase
  endfunction

  function automatic logic [63:0] quieted(logic [63:0] v);
    return v | 64'h0008000000000000;
  endfunction

  // Reference ordering derived from the requirements
  task automatic refModel(output logic [71:0] exp, output string tag);
    logic ps, eV, eI, eP;
    logic [63:0] eR;
    logic [2:0] eN;
    logic pInf, pZero;
    ps = xSign ^ ySign ^ negProduct;              // R11
    eV = 1'b1; eI = 1'b0; eP = 1'b0; eR = '0; eN = '0;
    pInf  = (xClass == C_INF) || (yClass == C_INF);
    pZero = (xClass == C_ZERO) || (yClass == C_ZERO);
    if (zClass == C_SNAN) begin
      eR = quieted(zRaw); eI = 1'b1; tag = "R2";
    end else if (xClass == C_SNAN) begin
      eR = quieted(xRaw); eI = 1'b1; tag = "R3";
    end else if (yClass == C_SNAN) begin
      eR = quieted(yRaw); eI = 1'b1; tag = "R3";
    end else if (xClass == C_QNAN) begin
      eR = xRaw; tag = "R4";
    end else if (yClass == C_QNAN) begin
      eR = yRaw; tag = "R4";
    end else if (zClass == C_QNAN) begin
      eR = zRaw; tag = "R5";
    end else if (pInf && pZero) begin
      eR = DNAN; eI = 1'b1; tag = "R6";
    end else if (pInf) begin
      tag = "R7";
      if (zClass == C_INF && zSign != ps) begin eR = DNAN; eI = 1'b1; end
      else eR = {ps, 11'h7FF, 52'd0};
    end else if (pZero) begin
      tag = "R8";
      eR = (zClass == C_INF) ? {zSign, 11'h7FF, 52'd0} : zRaw;
    end else if (zClass == C_INF) begin
      eR = {zSign, 11'h7FF, 52'd0}; tag = "R9";
    end else begin
      eV = 1'b0; eP = 1'b1; tag = "R10";
      eN = {zClass == C_DNORM, xClass == C_DNORM, yClass == C_DNORM};
    end
    exp = {eV, eR, eI, eP, eN, ps};
  endtask

  task automatic applyCase(int zc, int xc, int yc, logic zs, logic xs, logic ys, logic ng);
    logic [71:0] exp, got;
    string tag;
    @(negedge clk);
    zClass = 3'(zc); xClass = 3'(xc); yClass = 3'(yc);
    zSign = zs; xSign = xs; ySign = ys; negProduct = ng;
    zRaw = mkRaw(zc, zs); xRaw = mkRaw(xc, xs); yRaw = mkRaw(yc, ys);
    @(posedge clk);
    #1;
    refModel(exp, tag);
    got = {bypassValid, bypassResult, invalidOp, proceed, normReqZ, normReqX, normReqY, prodSign};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cls z%0d x%0d y%0d: got v=%b res=%h inv=%b pr=%b n=%b%b%b ps=%b exp v=%b res=%h inv=%b pr=%b n=%b ps=%b (R1/R11 fields)",
               tag, zc, xc, yc, bypassValid, bypassResult, invalidOp, proceed,
               normReqZ, normReqX, normReqY, prodSign,
               exp[71], exp[70:7], exp[6], exp[5], exp[4:2], exp[0]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: got cycles=%0d expected fewer", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Quiet starting vector: zero times zero plus zero (R8, R1)
    applyCase(C_ZERO, C_ZERO, C_ZERO, 0, 0, 0, 0);
    applyCase(C_SNAN, C_SNAN, C_QNAN, 1, 0, 0, 0);   // R2 addend wins
    applyCase(C_NORM, C_SNAN, C_SNAN, 0, 1, 0, 0);   // R3 x first
    applyCase(C_QNAN, C_QNAN, C_SNAN, 0, 0, 1, 0);   // R3 y signalling beats x quiet
    applyCase(C_NORM, C_NORM, C_QNAN, 0, 0, 0, 0);   // R4 y quiet
    applyCase(C_QNAN, C_QNAN, C_QNAN, 0, 1, 0, 0);   // R4 x quiet first
    applyCase(C_QNAN, C_NORM, C_NORM, 1, 0, 0, 0);   // R5
    applyCase(C_QNAN, C_INF, C_ZERO, 0, 0, 0, 0);    // R5 beats inf*0
    applyCase(C_NORM, C_ZERO, C_INF, 0, 0, 0, 0);    // R6
    applyCase(C_INF, C_INF, C_NORM, 0, 0, 0, 0);     // R7 same sign
    applyCase(C_INF, C_INF, C_NORM, 1, 0, 0, 0);     // R7 opposite sign
    applyCase(C_INF, C_INF, C_INF, 1, 0, 0, 1);      // R7 with R11 negate
    applyCase(C_INF, C_DNORM, C_ZERO, 1, 0, 0, 0);   // R8 inf addend
    applyCase(C_DNORM, C_ZERO, C_NORM, 1, 0, 1, 0);  // R8 addend passes
    applyCase(C_INF, C_NORM, C_DNORM, 1, 1, 0, 0);   // R9
    applyCase(C_DNORM, C_DNORM, C_DNORM, 0, 0, 0, 0);// R10 all normalize
    applyCase(C_NORM, C_NORM, C_DNORM, 0, 1, 1, 1);  // R10 and R11
    for (int i = 0; i < 3000; i++) begin
      applyCase($urandom_range(5, 0), $urandom_range(5, 0), $urandom_range(5, 0),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule